// File: doc/BRIEF.md
# Two-Wire Bus Ownership Arbiter

This block decides when a bus-master device may put a transfer on a shared external bus. An external arbiter hands the bus to the device with a single grant wire. The device answers on a single drive wire while it is actively using the bus. Between those two wires the block tracks three ownership modes:

- **none**: another master owns the bus.
- **implicit**: the bus is granted, but nothing is queued, so the drive wire stays low.
- **explicit**: the bus is granted and a transfer is running, so the drive wire is high.

The bus engine sends a one-cycle request pulse for each transfer it wants to run, and a one-cycle done pulse when the running transfer finishes. The block answers with a one-cycle start pulse when the engine may launch the transfer. Once a transfer has started, the bus is held until that transfer finishes, even if the arbiter withdraws the grant in the middle. A request raised while the bus is not granted is held until the grant arrives.

Top module: `bus_owner_ctrl`

## Requirements
- R1: During and right after reset, `own_mode_o` is 0 (none), and both `bus_drive_o` and `xfer_start_o` are low.
- R2: The grant input passes through `GRANT_STAGES` registers (default 1) before the arbiter acts on it. With the default, a change on `bus_grant_i` before clock edge k changes `own_mode_o` at edge k+1 at the earliest, and never at edge k.
- R3: With the grant seen and no request pending, `own_mode_o` becomes 1 (implicit) and `bus_drive_o` stays low.
- R4: A request that is pending while the block is in implicit mode moves it to `own_mode_o` = 2 (explicit) on the next edge. On that edge `bus_drive_o` rises and `xfer_start_o` pulses for one cycle.
- R5: `xfer_start_o` is high only while `bus_drive_o` is high. A start for a new transfer also needs the grant to have been seen on the previous cycle.
- R6: While `bus_drive_o` is high and no done pulse arrives, `bus_drive_o` stays high, whatever the grant does.
- R7: A done pulse in explicit mode with the grant no longer seen sets `own_mode_o` to 0 and lowers `bus_drive_o` on the next edge.
- R8: A done pulse in explicit mode, with the grant still seen and no request pending, sets `own_mode_o` to 1 and lowers `bus_drive_o` on the next edge.
- R9: A request pulse raised while the grant is not seen is remembered. No start is issued until the grant is seen. The start then follows on the edge after the grant is seen, going straight from none to explicit.
- R10: A done pulse in explicit mode, with the grant seen and another request pending, keeps `own_mode_o` at 2 and `bus_drive_o` high, and pulses `xfer_start_o` on the next edge.
- R11: In implicit mode, losing the grant sets `own_mode_o` to 0 on the edge after the grant is seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_grant_i | input | 1 | Grant from the external arbiter, active high |
| xfer_req_i | input | 1 | One-cycle pulse: the engine wants one transfer |
| xfer_done_i | input | 1 | One-cycle pulse: the running transfer has finished |
| bus_drive_o | output | 1 | High while the device actively drives the bus |
| xfer_start_o | output | 1 | One-cycle pulse: the engine may launch a transfer |
| own_mode_o | output | 2 | Ownership mode: 0 none, 1 implicit, 2 explicit |

## Verification
The bench withdraws the grant in the middle of a transfer. A design that released early would drop the drive wire before the done pulse, and so would drive the bus at the same time as the next master. It also raises requests while the grant is absent. A design that lost them would never start; one that ignored the grant would start on a bus it does not own. A done pulse that meets a fresh pending request tests the back-to-back path. A design that fell back to implicit mode there would show a one-cycle gap on the drive wire. Random grant, request and done traffic, checked every cycle against a bench model, catches an extra register stage or a missing one in the grant path.

// File: rtl/busown_pkg.sv
package busown_pkg;

    typedef enum logic [1:0] {
        MODE_NONE     = 2'd0,
        MODE_IMPLICIT = 2'd1,
        MODE_EXPLICIT = 2'd2
    } own_mode_e;

    typedef struct packed {
        own_mode_e mode;
        logic      drive;
        logic      start;
    } arb_state_t;

endpackage

// File: rtl/busown_grant_sync.sv
module busown_grant_sync #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_raw,
    output logic grant_seen
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d;
    logic [LAST:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                chain_d[0] = grant_raw;
            end
        end else begin : g_multi
            always_comb begin
                chain_d = {chain_q[LAST-1:0], grant_raw};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign grant_seen = chain_q[LAST];
endmodule

// File: rtl/busown_req_hold.sv
module busown_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic req_pulse,
    input  logic take,
    output logic pending
);
    logic pend_d;
    logic pend_q;

    // A start consumes the held request; a pulse in the same cycle survives.
    always_comb begin
        pend_d = (pend_q & ~take) | req_pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pending = pend_q;
endmodule

// File: rtl/busown_arb_fsm.sv
module busown_arb_fsm
    import busown_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      grant_seen,
    input  logic      pending,
    input  logic      done,
    output logic      start_next,
    output own_mode_e mode,
    output logic      drive,
    output logic      start
);
    arb_state_t st_d;
    arb_state_t st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        unique case (st_q.mode)
            MODE_NONE: begin
                if (grant_seen && pending) begin
                    st_d.mode  = MODE_EXPLICIT;
                    st_d.drive = 1'b1;
                    st_d.start = 1'b1;
                end else if (grant_seen) begin
                    st_d.mode = MODE_IMPLICIT;
                end
            end
            MODE_IMPLICIT: begin
                if (!grant_seen) begin
                    st_d.mode = MODE_NONE;
                end else if (pending) begin
                    st_d.mode  = MODE_EXPLICIT;
                    st_d.drive = 1'b1;
                    st_d.start = 1'b1;
                end
            end
            MODE_EXPLICIT: begin
                // The bus is held until the running transfer reports done.
                if (done) begin
                    if (grant_seen && pending) begin
                        st_d.start = 1'b1;
                    end else if (grant_seen) begin
                        st_d.mode  = MODE_IMPLICIT;
                        st_d.drive = 1'b0;
                    end else begin
                        st_d.mode  = MODE_NONE;
                        st_d.drive = 1'b0;
                    end
                end
            end
            default: begin
                st_d.mode  = MODE_NONE;
                st_d.drive = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_NONE, drive: 1'b0, start: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign start_next = st_d.start;
    assign mode       = st_q.mode;
    assign drive      = st_q.drive;
    assign start      = st_q.start;
endmodule

// File: rtl/bus_owner_ctrl.sv
module bus_owner_ctrl
    import busown_pkg::*;
#(
    parameter int GRANT_STAGES = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_grant_i,
    input  logic       xfer_req_i,
    input  logic       xfer_done_i,
    output logic       bus_drive_o,
    output logic       xfer_start_o,
    output logic [1:0] own_mode_o
);
    logic      grant_seen;
    logic      pend_q;
    logic      take;
    own_mode_e mode;

    busown_grant_sync #(.STAGES(GRANT_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant_raw  (bus_grant_i),
        .grant_seen (grant_seen)
    );

    busown_req_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_pulse (xfer_req_i),
        .take      (take),
        .pending   (pend_q)
    );

    busown_arb_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant_seen (grant_seen),
        .pending    (pend_q),
        .done       (xfer_done_i),
        .start_next (take),
        .mode       (mode),
        .drive      (bus_drive_o),
        .start      (xfer_start_o)
    );

    assign own_mode_o = mode;
endmodule

// File: rtl/busown_checker.sv
module busown_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       xfer_done_i,
    input logic       bus_drive_o,
    input logic       xfer_start_o,
    input logic [1:0] own_mode_o,
    input logic       grant_seen,
    input logic       pend_q
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (own_mode_o == 2'd0 && !bus_drive_o && !xfer_start_o));

    p_implicit_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        own_mode_o == 2'd1 |-> !bus_drive_o);

    p_start_driving_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start_o |-> bus_drive_o);

    p_hold_until_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_drive_o && !xfer_done_i) |=> bus_drive_o);

    p_release_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (own_mode_o == 2'd2 && xfer_done_i && !grant_seen) |=> (own_mode_o == 2'd0 && !bus_drive_o));

    p_release_implicit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (own_mode_o == 2'd2 && xfer_done_i && grant_seen && !pend_q) |=> (own_mode_o == 2'd1));

    p_start_needs_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start_o |-> $past(grant_seen));

    p_back_to_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (own_mode_o == 2'd2 && xfer_done_i && grant_seen && pend_q) |=> (bus_drive_o && xfer_start_o));

    p_grant_lost_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (own_mode_o == 2'd1 && !grant_seen) |=> (own_mode_o == 2'd0));
endmodule

bind bus_owner_ctrl busown_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .xfer_done_i  (xfer_done_i),
    .bus_drive_o  (bus_drive_o),
    .xfer_start_o (xfer_start_o),
    .own_mode_o   (own_mode_o),
    .grant_seen   (grant_seen),
    .pend_q       (pend_q)
);

// File: tb/bus_owner_ctrl_bench.sv
module bus_owner_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       grant = 1'b0;
    logic       req = 1'b0;
    logic       done = 1'b0;
    logic       drive;
    logic       start;
    logic [1:0] mode;

    int n_cmp = 0;
    int n_bad = 0;

    bit         watchdog_hit = 1'b0;
    int         cyc = 0;

    // Reference model state (bench's own reading of the requirements)
    bit       m_g;
    bit       m_p;
    bit [1:0] m_mode;
    bit       m_start;

    always #5 clk = ~clk;

    bus_owner_ctrl u_bus_owner_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_grant_i  (grant),
        .xfer_req_i   (req),
        .xfer_done_i  (done),
        .bus_drive_o  (drive),
        .xfer_start_o (start),
        .own_mode_o   (mode)
    );

    function automatic bit [1:0] next_mode(bit [1:0] cur, bit g, bit p, bit d);
        case (cur)
            2'd0: return (g && p) ? 2'd2 : (g ? 2'd1 : 2'd0);
            2'd1: return !g ? 2'd0 : (p ? 2'd2 : 2'd1);
            2'd2: return !d ? 2'd2 : ((g && p) ? 2'd2 : (g ? 2'd1 : 2'd0));
            default: return 2'd0;
        endcase
    endfunction

    function automatic bit next_start(bit [1:0] cur, bit g, bit p, bit d);
        case (cur)
            2'd0: return g && p;
            2'd1: return g && p;
            2'd2: return d && g && p;
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_g = 0; m_p = 0; m_mode = 0; m_start = 0;
        end else begin
            bit st;
            st = next_start(m_mode, m_g, m_p, done);
            m_mode  = next_mode(m_mode, m_g, m_p, done);
            m_start = st;
            m_p     = (m_p && !st) || req;
            m_g     = grant;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        watchdog_hit = 1'b1;
    end

    initial begin
        void'($urandom(32'h0000_51A7));
        cycles(3);
        check("R1 mode after reset", mode, 0);
        check("R1 drive after reset", drive, 0);
        check("R1 start after reset", start, 0);
        rst_n = 1'b1;
        cycles(1);
        check("R1 mode after release", mode, 0);

        // R2 / R3: grant arrives, no request
        grant = 1'b1;
        cycles(1);
        check("R2 mode not yet changed", mode, 0);
        cycles(1);
        check("R3 implicit mode", mode, 1);
        check("R3 drive low in implicit", drive, 0);

        // R4: request while implicit
        req = 1'b1;
        cycles(1);
        req = 1'b0;
        check("R4 still implicit while latching", mode, 1);
        cycles(1);
        check("R4 explicit mode", mode, 2);
        check("R4 start pulse", start, 1);
        check("R4 drive high", drive, 1);
        cycles(1);
        check("R5 start is one cycle", start, 0);

        // R6: grant withdrawn mid-transfer
        grant = 1'b0;
        cycles(3);
        check("R6 drive held without grant", drive, 1);
        check("R6 mode held explicit", mode, 2);

        // R7: done with grant gone
        done = 1'b1;
        cycles(1);
        done = 1'b0;
        check("R7 mode none after done", mode, 0);
        check("R7 drive released", drive, 0);

        // R9: request without grant is held
        req = 1'b1;
        cycles(1);
        req = 1'b0;
        cycles(4);
        check("R9 no start without grant", start, 0);
        check("R9 mode still none", mode, 0);
        grant = 1'b1;
        cycles(1);
        check("R9 no start before grant seen", start, 0);
        cycles(1);
        check("R9 start after grant seen", start, 1);
        check("R9 straight to explicit", mode, 2);

        // R10: back-to-back
        req = 1'b1;
        cycles(1);
        req = 1'b0;
        done = 1'b1;
        cycles(1);
        done = 1'b0;
        check("R10 second start", start, 1);
        check("R10 drive continuous", drive, 1);
        check("R10 mode stays explicit", mode, 2);

        // R8: done with grant, nothing pending
        done = 1'b1;
        cycles(1);
        done = 1'b0;
        check("R8 back to implicit", mode, 1);
        check("R8 drive low", drive, 0);

        // R11: grant lost while implicit
        grant = 1'b0;
        cycles(1);
        check("R11 not yet none", mode, 1);
        cycles(1);
        check("R11 mode none", mode, 0);

        // Random traffic against the model
        for (int k = 0; k < 4000; k++) begin
            if (($urandom % 8) == 0) grant = ~grant;
            req  = (($urandom % 4) == 0);
            done = (($urandom % 3) == 0);
            cycles(1);
            check("R3 mode vs model", mode, m_mode);
            check("R6 drive vs model", drive, (m_mode == 2'd2));
            check("R5 start vs model", start, m_start);
            if (watchdog_hit) break;
        end
        req = 1'b0; done = 1'b0;

        if (watchdog_hit) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual expired expected finished");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule